// File: doc/BRIEF.md
# Receive Acceptance Filter Router

This block sits behind a CAN bit-level receiver and decides what happens to each received frame identifier. It keeps a bank of filter pairs. Each pair is a mask word, an identifier word and an enable bit. A host write port loads the pairs, the enable bits and a buffer partition threshold. When a frame identifier arrives with its valid strobe, the block walks the filters one per clock, starting at index 0 and going upward, and stops at the first enabled filter that matches. The index of that filter, set against the threshold, selects receive buffer 0 or receive buffer 1. The block then emits exactly one outcome pulse: a store strobe, an overflow for the selected buffer when that buffer reports full, or a no-match.

The 32-bit identifier word is laid out as follows:

| Bits | Content |
|------|---------|
| [31:21] | 11-bit standard ID |
| 20 | substitute remote request |
| 19 | extended-format flag |
| [18:1] | 18-bit extended ID |
| 0 | remote request |

A filter whose mask has bit 19 clear compares only bits [31:21].

The control is a three-state machine:
- **ST_IDLE** waits for a frame. Its transition *accept* goes to ST_SCAN when `frm_valid` is high.
- **ST_SCAN** tests one filter per cycle. Its transition *hit* goes to ST_ROUTE on the first enabled match. Its transition *exhaust* goes to ST_ROUTE after the last index with no match. Its transition *advance* stays in ST_SCAN and moves to the next index.
- **ST_ROUTE** drives the outcome pulse for one cycle. Its transition *release* always returns to ST_IDLE.

Top module: `acc_filter_router`

## Requirements
- R1: A filter matches when (frame_id AND mask) equals (filter_id AND mask). The mask used is the effective mask defined in R6. A frame that differs from the filter identifier in any bit kept by that mask does not match.
- R2: Filters are tested one per clock, in increasing index order. The first enabled match wins and no later filter is consulted. The outcome for a hit at index j appears j+1 cycles after the accepting edge. The outcome for no match appears NUM_FILT cycles after that edge. `match_idx` carries the winning index during the outcome pulse.
- R3: A winning index less than or equal to the threshold selects buffer 0. A larger index selects buffer 1. The selected buffer, when not full, gets a `store0` or `store1` pulse.
- R4: If the selected buffer's full flag is high during the outcome cycle, there is no store pulse. Instead `ovf0` or `ovf1` of that buffer pulses, whatever the state of the other buffer.
- R5: When no enabled filter matches, including the case where every enable is 0, only `no_match` pulses and neither buffer is stored to.
- R6: When bit 19 of a filter mask is 0, only bits [31:21] take part in the comparison. When bit 19 of the mask is 1, the whole masked word is compared.
- R7: Host write encodings are given by `host_kind`:
  - 0 writes the mask;
  - 1 writes the filter identifier;
  - 2 writes the enable from `host_wdata[0]`;
  - 3 writes the threshold from `host_wdata[IDX_W-1:0]`.

  A mask or identifier write to an enabled pair has no effect on matching, and it sets `wr_err`. Once set, `wr_err` stays high until reset.
- R8: `busy` is high from the accepting edge through the outcome cycle. A `frm_valid` seen while `busy` is high is ignored and produces no outcome.
- R9: After reset the following all read 0: `busy`, the five outcome pulses, `wr_err`, every enable bit and the threshold. Reset does not clear the mask or identifier contents.
- R10: Each accepted frame produces exactly one of `store0`, `store1`, `ovf0`, `ovf1` or `no_match`, and that outcome lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_kind | input | 2 | Write target: 0 mask, 1 identifier, 2 enable, 3 threshold |
| host_idx | input | IDX_W | Filter pair index for the write |
| host_wdata | input | ID_W | Write data |
| frm_valid | input | 1 | Received identifier valid |
| frm_id | input | ID_W | Received identifier word |
| full0 | input | 1 | Buffer 0 full |
| full1 | input | 1 | Buffer 1 full |
| busy | output | 1 | Scan or routing in progress |
| store0 | output | 1 | Store pulse to buffer 0 |
| store1 | output | 1 | Store pulse to buffer 1 |
| ovf0 | output | 1 | Buffer 0 overflow pulse |
| ovf1 | output | 1 | Buffer 1 overflow pulse |
| no_match | output | 1 | No filter accepted the frame |
| match_idx | output | IDX_W | Winning filter index, valid with a store or overflow pulse |
| wr_err | output | 1 | Sticky: write to an enabled pair attempted |

## Verification
The situation hardest to reach from the ports is two enabled filters that both match one frame, since that is the only way to show that the scan stops at the lower index. The stimulus programs two pairs with the same standard-ID-only mask. It shows the lower index winning, then disables that pair and shows the upper index taking over with its later latency. The threshold is then swept across the winning index while each full flag is raised in turn, which reaches overflow with the other buffer empty. A second frame is injected in the middle of a scan to show it is ignored.

// File: rtl/acf_pkg.sv
package acf_pkg;

    // Identifier word layout
    localparam int STD_LSB = 21;
    localparam int IDE_BIT = 19;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ROUTE = 2'd2
    } acf_state_e;

    typedef enum logic [1:0] {
        HK_MASK = 2'd0,
        HK_ID   = 2'd1,
        HK_EN   = 2'd2,
        HK_THR  = 2'd3
    } host_kind_e;

endpackage

// File: rtl/acf_match_unit.sv
module acf_match_unit
    import acf_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic [ID_W-1:0] frame_id,
    input  logic [ID_W-1:0] mask,
    input  logic [ID_W-1:0] filt_id,
    output logic            hit
);

    localparam logic [ID_W-1:0] STD_ONLY = {ID_W{1'b1}} << STD_LSB;

    logic [ID_W-1:0] eff_mask;

    always_comb begin
        eff_mask = mask[IDE_BIT] ? mask : (mask & STD_ONLY);
        hit      = ((frame_id & eff_mask) == (filt_id & eff_mask));
    end

endmodule

// File: rtl/acf_filter_bank.sv
module acf_filter_bank
    import acf_pkg::*;
#(
    parameter int NUM_FILT = 32,
    parameter int ID_W     = 32,
    parameter int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_kind,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [ID_W-1:0]  host_wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_mask,
    output logic [ID_W-1:0]  rd_fid,
    output logic             rd_en,
    output logic [IDX_W-1:0] thr_q,
    output logic             wr_err
);

    logic [ID_W-1:0]     mask_mem [NUM_FILT];
    logic [ID_W-1:0]     fid_mem  [NUM_FILT];
    logic [NUM_FILT-1:0] en_q;
    logic                idx_ok;
    logic                pair_wr;
    logic                pair_locked;

    always_comb begin
        idx_ok      = (int'(host_idx) < NUM_FILT);
        pair_wr     = host_wr && idx_ok &&
                      ((host_kind == HK_MASK) || (host_kind == HK_ID));
        pair_locked = idx_ok && en_q[host_idx];
    end

    // Pair storage: no reset, write only while the pair is disabled
    always_ff @(posedge clk) begin
        if (pair_wr && !pair_locked) begin
            if (host_kind == HK_MASK) begin
                mask_mem[host_idx] <= host_wdata;
            end else begin
                fid_mem[host_idx]  <= host_wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_en
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
            end else if (host_wr && host_kind == HK_EN && host_idx == IDX_W'(g)) begin
                en_q[g] <= host_wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            if (host_wr && host_kind == HK_THR) begin
                thr_q <= host_wdata[IDX_W-1:0];
            end
            if (pair_wr && pair_locked) begin
                wr_err <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_mask = mask_mem[rd_idx];
        rd_fid  = fid_mem[rd_idx];
        rd_en   = en_q[rd_idx];
    end

endmodule

// File: rtl/acf_scan_fsm.sv
module acf_scan_fsm
    import acf_pkg::*;
#(
    parameter int NUM_FILT = 32,
    parameter int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  logic             hit_now,
    input  logic [IDX_W-1:0] thr,
    input  logic             full0,
    input  logic             full1,
    output logic             accept,
    output logic [IDX_W-1:0] scan_idx,
    output logic             busy,
    output logic             store0,
    output logic             store1,
    output logic             ovf0,
    output logic             ovf1,
    output logic             no_match,
    output logic [IDX_W-1:0] match_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FILT - 1);

    acf_state_e       state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic [IDX_W-1:0] hidx_q, hidx_n;
    logic             found_q, found_n;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        hidx_n  = hidx_q;
        found_n = found_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frm_valid) begin          // accept
                    state_n = ST_SCAN;
                    idx_n   = '0;
                    found_n = 1'b0;
                end
            end
            ST_SCAN: begin
                if (hit_now) begin            // hit
                    state_n = ST_ROUTE;
                    found_n = 1'b1;
                    hidx_n  = idx_q;
                end else if (idx_q == LAST_IDX) begin  // exhaust
                    state_n = ST_ROUTE;
                    found_n = 1'b0;
                end else begin                // advance
                    idx_n = idx_q + 1'b1;
                end
            end
            ST_ROUTE: begin                   // release
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            hidx_q  <= '0;
            found_q <= 1'b0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            hidx_q  <= hidx_n;
            found_q <= found_n;
        end
    end

    // Outputs
    always_comb begin
        logic to_buf0;
        to_buf0   = (hidx_q <= thr);
        accept    = (state_q == ST_IDLE) && frm_valid;
        busy      = (state_q != ST_IDLE);
        scan_idx  = idx_q;
        match_idx = hidx_q;
        store0    = 1'b0;
        store1    = 1'b0;
        ovf0      = 1'b0;
        ovf1      = 1'b0;
        no_match  = 1'b0;
        unique case (state_q)
            ST_ROUTE: begin
                if (!found_q) begin
                    no_match = 1'b1;
                end else if (to_buf0) begin
                    store0 = !full0;
                    ovf0   = full0;
                end else begin
                    store1 = !full1;
                    ovf1   = full1;
                end
            end
            ST_IDLE, ST_SCAN: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_filter_router.sv
module acc_filter_router
    import acf_pkg::*;
#(
    parameter  int NUM_FILT = 32,
    parameter  int ID_W     = 32,
    localparam int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_kind,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [ID_W-1:0]  host_wdata,
    input  logic             frm_valid,
    input  logic [ID_W-1:0]  frm_id,
    input  logic             full0,
    input  logic             full1,
    output logic             busy,
    output logic             store0,
    output logic             store1,
    output logic             ovf0,
    output logic             ovf1,
    output logic             no_match,
    output logic [IDX_W-1:0] match_idx,
    output logic             wr_err
);

    logic [ID_W-1:0]  frame_q;
    logic [IDX_W-1:0] scan_idx;
    logic [ID_W-1:0]  rd_mask;
    logic [ID_W-1:0]  rd_fid;
    logic             rd_en;
    logic [IDX_W-1:0] thr_q;
    logic             cmp_hit;
    logic             accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (accept) begin
            frame_q <= frm_id;
        end
    end

    acf_filter_bank #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_kind  (host_kind),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .rd_idx     (scan_idx),
        .rd_mask    (rd_mask),
        .rd_fid     (rd_fid),
        .rd_en      (rd_en),
        .thr_q      (thr_q),
        .wr_err     (wr_err)
    );

    acf_match_unit #(
        .ID_W (ID_W)
    ) u_match (
        .frame_id (frame_q),
        .mask     (rd_mask),
        .filt_id  (rd_fid),
        .hit      (cmp_hit)
    );

    acf_scan_fsm #(
        .NUM_FILT (NUM_FILT),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .hit_now   (rd_en && cmp_hit),
        .thr       (thr_q),
        .full0     (full0),
        .full1     (full1),
        .accept    (accept),
        .scan_idx  (scan_idx),
        .busy      (busy),
        .store0    (store0),
        .store1    (store1),
        .ovf0      (ovf0),
        .ovf1      (ovf1),
        .no_match  (no_match),
        .match_idx (match_idx)
    );

endmodule

// File: rtl/acf_router_chk.sv
module acf_router_chk #(
    parameter int NUM_FILT = 32,
    parameter int IDX_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic             full0,
    input logic             full1,
    input logic             busy,
    input logic             store0,
    input logic             store1,
    input logic             ovf0,
    input logic             ovf1,
    input logic             no_match,
    input logic [IDX_W-1:0] match_idx,
    input logic             wr_err,
    input logic [IDX_W-1:0] thr_q
);

    logic dec;
    int   busy_cnt;

    assign dec = store0 | store1 | ovf0 | ovf1 | no_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1;
        end else begin
            busy_cnt <= 0;
        end
    end

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store0, store1, ovf0, ovf1, no_match}));

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> !dec);

    p_store0_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        store0 |-> !full0);

    p_store1_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        store1 |-> !full1);

    p_ovf0_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf0 |-> full0);

    p_ovf1_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf1 |-> full1);

    p_buf0_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store0 || ovf0) |-> (match_idx <= thr_q));

    p_buf1_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store1 || ovf1) |-> (match_idx > thr_q));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && frm_valid) |=> busy);

    p_dec_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> busy);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> !busy);

    p_wrerr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    p_scan_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt <= NUM_FILT));

endmodule

bind acc_filter_router acf_router_chk #(
    .NUM_FILT (NUM_FILT),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .full0     (full0),
    .full1     (full1),
    .busy      (busy),
    .store0    (store0),
    .store1    (store1),
    .ovf0      (ovf0),
    .ovf1      (ovf1),
    .no_match  (no_match),
    .match_idx (match_idx),
    .wr_err    (wr_err),
    .thr_q     (thr_q)
);

// File: tb/test_acc_filter_router.sv
module test_acc_filter_router;

    localparam int N  = 32;
    localparam int IW = 5;
    localparam int W  = 32;

    // Outcome codes used by the bench
    localparam int OC_S0 = 1, OC_S1 = 2, OC_O0 = 3, OC_O1 = 4, OC_NM = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [1:0]    host_kind = 2'd0;
    logic [IW-1:0] host_idx = '0;
    logic [W-1:0]  host_wdata = '0;
    logic          frm_valid = 1'b0;
    logic [W-1:0]  frm_id = '0;
    logic          full0 = 1'b0;
    logic          full1 = 1'b0;
    logic          busy, store0, store1, ovf0, ovf1, no_match, wr_err;
    logic [IW-1:0] match_idx;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    acc_filter_router #(.NUM_FILT(N), .ID_W(W)) i_acc_filter_router (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_kind(host_kind),
        .host_idx(host_idx), .host_wdata(host_wdata), .frm_valid(frm_valid),
        .frm_id(frm_id), .full0(full0), .full1(full1), .busy(busy),
        .store0(store0), .store1(store1), .ovf0(ovf0), .ovf1(ovf1),
        .no_match(no_match), .match_idx(match_idx), .wr_err(wr_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [W-1:0] m_mask [N];
    bit [W-1:0] m_fid  [N];
    bit         m_en   [N];
    int  m_thr = 0;
    bit  m_err = 0;
    bit  m_busy = 0;
    bit  m_route = 0;
    bit  m_hit = 0;
    int  m_idx = 0;
    int  m_left = 0;

    function automatic bit ref_match(bit [W-1:0] id, bit [W-1:0] mk, bit [W-1:0] fd);
        bit [W-1:0] em;
        em = mk[19] ? mk : (mk & 32'hFFE0_0000);
        return (id & em) == (fd & em);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_en[i] = 0;
            m_thr = 0; m_err = 0; m_busy = 0; m_route = 0; m_hit = 0; m_idx = 0;
        end else begin
            if (m_route) begin
                m_route = 0;
                m_busy  = 0;
            end else if (m_busy) begin
                m_left--;
                if (m_left == 0) m_route = 1;
            end else if (frm_valid) begin
                m_hit = 0;
                for (int i = 0; i < N; i++) begin
                    if (!m_hit && m_en[i] && ref_match(frm_id, m_mask[i], m_fid[i])) begin
                        m_hit = 1;
                        m_idx = i;
                    end
                end
                m_busy = 1;
                m_left = m_hit ? m_idx + 1 : N;
            end
            if (host_wr) begin
                case (host_kind)
                    2'd0: if (m_en[host_idx]) m_err = 1; else m_mask[host_idx] = host_wdata;
                    2'd1: if (m_en[host_idx]) m_err = 1; else m_fid[host_idx] = host_wdata;
                    2'd2: m_en[host_idx] = host_wdata[0];
                    default: m_thr = int'(host_wdata[IW-1:0]);
                endcase
            end
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit b0;
            b0 = (m_idx <= m_thr);
            chk("R8 busy", busy, m_busy);
            chk("R3 store0", store0, m_route && m_hit && b0 && !full0);
            chk("R3 store1", store1, m_route && m_hit && !b0 && !full1);
            chk("R4 ovf0", ovf0, m_route && m_hit && b0 && full0);
            chk("R4 ovf1", ovf1, m_route && m_hit && !b0 && full1);
            chk("R5 no_match", no_match, m_route && !m_hit);
            chk("R7 wr_err", wr_err, m_err);
            if (m_route && m_hit) chk("R2 match_idx", match_idx, m_idx);
        end
    end

    // ---------------- stimulus ----------------
    task automatic hwrite(input int kind, input int idx, input logic [W-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_kind = 2'(kind); host_idx = IW'(idx); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic send(input logic [W-1:0] id, input int exp_code, input int exp_idx,
                        input int exp_lat, input string tag, input bit poke);
        int waited;
        int code;
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id;
        @(negedge clk);
        frm_valid = 1'b0;
        waited = 0;
        while (!(store0 | store1 | ovf0 | ovf1 | no_match) && waited < N + 8) begin
            if (poke && waited == 1) begin
                frm_valid = 1'b1; frm_id = ~id;
            end else begin
                frm_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        frm_valid = 1'b0;
        code = store0 ? OC_S0 : store1 ? OC_S1 : ovf0 ? OC_O0 : ovf1 ? OC_O1 :
               no_match ? OC_NM : 0;
        chk({tag, " outcome"}, code, exp_code);
        chk({tag, " R2 latency"}, waited, exp_lat);
        if (exp_code != OC_NM) chk({tag, " R2 index"}, match_idx, exp_idx);
        chk("R10 one outcome", $countones({store0, store1, ovf0, ovf1, no_match}), 1);
        @(negedge clk);
        chk("R10 single cycle", $countones({store0, store1, ovf0, ovf1, no_match}), 0);
        if (poke) begin
            int extra = 0;
            for (int k = 0; k < N + 4; k++) begin
                @(negedge clk);
                extra += $countones({store0, store1, ovf0, ovf1, no_match});
            end
            chk("R8 frame during busy ignored", extra, 0);
        end
    endtask

    localparam logic [W-1:0] STD_MASK = 32'hFFE0_0000;
    localparam logic [W-1:0] FRAME_A  = 32'h2460_0000 | 32'h0008_ABCD;
    localparam logic [W-1:0] FRAME_B  = 32'h135F_9BDF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 busy after reset", busy, 0);
        chk("R9 pulses after reset", {store0, store1, ovf0, ovf1, no_match}, 0);
        chk("R9 wr_err after reset", wr_err, 0);

        // All filters disabled after reset
        send(FRAME_A, OC_NM, 0, N, "R9 enables cleared / R5", 0);

        hwrite(0, 3, STD_MASK);
        hwrite(1, 3, 32'h2460_0000);
        hwrite(2, 3, 1);
        hwrite(3, 0, 5);
        send(FRAME_A, OC_S0, 3, 4, "R6 standard-only compare", 0);

        hwrite(0, 10, 32'hFFFF_FFFF);
        hwrite(1, 10, FRAME_B);
        hwrite(2, 10, 1);
        send(FRAME_B, OC_S1, 10, 11, "R3 index above threshold", 0);
        send(FRAME_B ^ 32'h0000_0100, OC_NM, 0, N, "R6 extended bits compared", 0);

        hwrite(0, 20, 32'h000F_0000);
        hwrite(1, 20, 32'h000A_0000);
        hwrite(2, 20, 1);
        send(32'h555A_1234, OC_S1, 20, 21, "R1 partial mask match", 0);
        send(32'h555B_1234, OC_NM, 0, N, "R1 partial mask miss", 0);

        hwrite(0, 7, STD_MASK);
        hwrite(1, 7, 32'h2460_0000);
        hwrite(2, 7, 1);
        send(FRAME_A, OC_S0, 3, 4, "R2 lowest index wins", 0);
        hwrite(2, 3, 0);
        send(FRAME_A, OC_S1, 7, 8, "R2 next filter after disable", 0);
        hwrite(3, 0, 7);
        send(FRAME_A, OC_S0, 7, 8, "R3 index equal threshold", 0);

        full0 = 1'b1;
        send(FRAME_A, OC_O0, 7, 8, "R4 buffer0 full other empty", 0);
        full0 = 1'b0;
        hwrite(3, 0, 6);
        full1 = 1'b1;
        send(FRAME_A, OC_O1, 7, 8, "R4 buffer1 full other empty", 0);
        full1 = 1'b0;

        hwrite(1, 7, 32'hFFFF_FFFF);
        chk("R7 wr_err set", wr_err, 1);
        hwrite(3, 0, 7);
        send(FRAME_A, OC_S0, 7, 8, "R7 locked write ignored", 0);
        hwrite(1, 3, 32'h0000_0000);
        chk("R7 wr_err sticky", wr_err, 1);

        send(FRAME_A, OC_S0, 7, 8, "R8 busy poke", 1);

        hwrite(0, 31, 32'hFFFF_FFFF);
        hwrite(1, 31, 32'hDEAD_BEEF);
        hwrite(2, 31, 1);
        hwrite(3, 0, 31);
        send(32'hDEAD_BEEF, OC_S0, 31, 32, "R2 last filter", 0);

        hwrite(2, 7, 0);
        hwrite(2, 10, 0);
        hwrite(2, 20, 0);
        hwrite(2, 31, 0);
        send(FRAME_A, OC_NM, 0, N, "R5 all disabled", 0);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule